// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain DMA Engine

This block is one memory-to-peripheral DMA channel. Software places a chain of 16-byte link descriptors in memory. Each link names a buffer and a byte count. Software then programs the chain base address and the total number of bytes it expects, and starts the channel. The engine fetches each link in turn and reads the buffer a 32-bit word at a time. It presents the bytes one by one, in address order, on a valid/ready byte stream. It stops after the link that carries the end-of-chain flag.

The engine does not run ahead. It asks for the next link only after the last byte of the current segment has been taken, and it never has more than one memory read in flight. A live byte counter can be read through the register port, so software can compute how many bytes remain. Pause and clear controls let software hold the channel or abort it. One-cycle pulses report completion, a length or descriptor error, and a per-link interrupt request.

Top module: `sg_chain_dma`

## Requirements
- R1: After reset, all four registers read 0, `st_valid` is low and no memory request is issued. The register word addresses are: 0 = chain base, 1 = total length, 2 = config, 3 = bytes done (read-only). Config bit 25 is clear, bit 26 is pause, bit 27 is busy (read-only) and bit 28 is done (read-only).
- R2: Writing the config word with bits 25 and 26 both 0 while the channel is idle starts a walk at the chain base. Busy (bit 27) reads 1 until the walk ends.
- R3: Link n sits at base + 16*n. The word at +0 is the control word and the word at +4 is the buffer address. The words at +8 and +12 are never read. Control bits [26:0] give the segment length, bit 27 requests an interrupt, bit 28 ends the chain and bit 30 marks a bad link. Bits 29 and 31 have no effect.
- R4: Each segment's bytes appear on `st_data` in ascending address order, starting at any byte alignment. A presented byte holds `st_valid` and a stable `st_data` until `st_ready` takes it.
- R5: When the end-of-chain link finishes with bytes done equal to the total length, `dma_done` pulses once. Config bit 28 then reads 1 until the next start or clear.
- R6: `dma_err` pulses instead of `dma_done` in three cases: the end-of-chain link finishes with a byte count different from the total; a non-final link finishes with the count at or above the total; or the eighth link finishes without an end-of-chain flag.
- R7: A link with control bit 30 set raises `dma_err` as soon as its control word arrives. None of its bytes are read or sent.
- R8: A link of length 0 moves no bytes, and the walk continues with the next link.
- R9: `link_irq` pulses once at the end of every completed link whose bit 27 is set.
- R10: The bytes-done register equals the number of stream bytes accepted since the start, and it rises by one per accepted byte.
- R11: Writing config with bit 26 set stops new memory requests and new stream bytes. A byte already presented stays until it is taken. Writing 0 resumes at the next byte, so the whole stream is unchanged.
- R12: Writing config with bit 25 set aborts the walk. The channel goes idle, the byte count reads 0, pause is dropped and neither pulse fires. A read response still in flight is discarded, and a new start works normally.
- R13: At most one memory read is outstanding at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | ADDR_W (32) | Byte address of the requested 32-bit word |
| mem_rvalid | input | 1 | Read data valid, any number of cycles after the request |
| mem_rdata | input | 32 | Read data word, little-endian byte lanes |
| st_valid | output | 1 | Stream byte valid |
| st_data | output | 8 | Stream byte |
| st_ready | input | 1 | Stream sink ready |
| dma_done | output | 1 | Chain completed pulse |
| dma_err | output | 1 | Length or descriptor error pulse |
| link_irq | output | 1 | Per-link interrupt request pulse |

## Verification
Some rules are checked every cycle by the assertions: stream hold-until-accepted, the single outstanding read, the quiet state while paused, the one-step growth of the byte counter, the idle state after a clear, and that done implies a matched length. Other behaviour only appears across a whole transfer, so the bench scenarios must show it. This covers byte order over odd alignments and word crossings, and the choice between done and error at the various chain ends. It also covers skipping of zero-length and bad links, interrupt counts, and an exact resume after a pause.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  localparam int WORD_W     = 32;
  localparam int LANES      = WORD_W / 8;
  localparam int LANE_W     = $clog2(LANES);
  localparam int LINK_BYTES = 16;
  localparam int SEG_LEN_W  = 27;

  // control word of a link
  localparam int LK_IRQ = 27;
  localparam int LK_EOC = 28;
  localparam int LK_BAD = 30;

  // config register bits
  localparam int CF_CLEAR = 25;
  localparam int CF_PAUSE = 26;
  localparam int CF_BUSY  = 27;
  localparam int CF_DONE  = 28;

  // register word addresses
  localparam logic [1:0] RG_BASE  = 2'd0;
  localparam logic [1:0] RG_TOTAL = 2'd1;
  localparam logic [1:0] RG_CFG   = 2'd2;
  localparam logic [1:0] RG_COUNT = 2'd3;

  typedef enum logic [2:0] {
    W_IDLE, W_LREQ, W_LWAIT, W_DREQ, W_DWAIT, W_SEND, W_SEGEND
  } walk_state_e;
endpackage

// File: rtl/sgdma_lane_pick.sv
module sgdma_lane_pick
  import sgdma_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [LANE_W-1:0] sel_i,
  output logic [7:0]        lane_o
);
  logic [7:0] lanes [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[g] = word_i[8*g +: 8];
  end

  assign lane_o = lanes[sel_i];
endmodule

// File: rtl/sgdma_regs.sv
module sgdma_regs
  import sgdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              busy,
  input  logic              done_p,
  input  logic [LEN_W-1:0]  count,
  output logic [ADDR_W-1:0] chain_base,
  output logic [LEN_W-1:0]  total_len,
  output logic              pause,
  output logic              start_p,
  output logic              clear_p
);
  logic done_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_base <= '0;
      total_len  <= '0;
      pause      <= 1'b0;
      start_p    <= 1'b0;
      clear_p    <= 1'b0;
      done_flag  <= 1'b0;
      rdata      <= '0;
    end else begin
      start_p <= 1'b0;
      clear_p <= 1'b0;
      if (done_p) done_flag <= 1'b1;
      if (we) begin
        case (addr)
          RG_BASE:  chain_base <= wdata[ADDR_W-1:0];
          RG_TOTAL: total_len  <= wdata[LEN_W-1:0];
          RG_CFG: begin
            if (wdata[CF_CLEAR]) begin
              clear_p   <= 1'b1;
              pause     <= 1'b0;
              done_flag <= 1'b0;
            end else begin
              pause <= wdata[CF_PAUSE];
              if (!wdata[CF_PAUSE] && !busy && !start_p) begin
                start_p   <= 1'b1;
                done_flag <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
      case (addr)
        RG_BASE:  rdata <= 32'(chain_base);
        RG_TOTAL: rdata <= 32'(total_len);
        RG_CFG: begin
          rdata           <= '0;
          rdata[CF_PAUSE] <= pause;
          rdata[CF_BUSY]  <= busy;
          rdata[CF_DONE]  <= done_flag;
        end
        default:  rdata <= 32'(count);
      endcase
    end
  end

  // R12: a clear leaves pause off on the next cycle
  a_r12_clear_unpause: assert property (@(posedge clk) disable iff (rst)
    clear_p |-> !pause);
endmodule

// File: rtl/sgdma_walker.sv
module sgdma_walker
  import sgdma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 32,
  parameter int MAX_LINKS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              clear,
  input  logic              pause,
  input  logic [ADDR_W-1:0] chain_base,
  input  logic [LEN_W-1:0]  total_len,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              st_valid,
  output logic [7:0]        st_data,
  input  logic              st_ready,
  output logic [LEN_W-1:0]  bytes_done,
  output logic              busy,
  output logic              done_p,
  output logic              err_p,
  output logic              irq_p
);
  localparam int LC_W = (MAX_LINKS > 1) ? $clog2(MAX_LINKS) : 1;

  walk_state_e          state;
  logic                 pend;
  logic                 word_k;
  logic [ADDR_W-1:0]    link_ptr;
  logic [LC_W-1:0]      link_cnt;
  logic [SEG_LEN_W-1:0] seg_len_q;
  logic                 lk_irq, lk_eoc;
  logic [SEG_LEN_W-1:0] seg_left;
  logic [ADDR_W-1:0]    buf_addr;
  logic [WORD_W-1:0]    data_word;
  logic [7:0]           cur_byte, nxt_byte;
  logic [LANE_W-1:0]    cur_lane, nxt_lane;
  logic                 lk_unused;

  assign lk_unused = ^{mem_rdata[31], mem_rdata[29]};
  assign cur_lane  = buf_addr[LANE_W-1:0];
  assign nxt_lane  = LANE_W'(cur_lane + 1'b1);
  assign busy      = (state != W_IDLE);

  sgdma_lane_pick u_cur (.word_i(data_word), .sel_i(cur_lane), .lane_o(cur_byte));
  sgdma_lane_pick u_nxt (.word_i(data_word), .sel_i(nxt_lane), .lane_o(nxt_byte));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= W_IDLE;
      pend       <= 1'b0;
      word_k     <= 1'b0;
      link_ptr   <= '0;
      link_cnt   <= '0;
      seg_len_q  <= '0;
      lk_irq     <= 1'b0;
      lk_eoc     <= 1'b0;
      seg_left   <= '0;
      buf_addr   <= '0;
      data_word  <= '0;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
      st_valid   <= 1'b0;
      st_data    <= '0;
      bytes_done <= '0;
      done_p     <= 1'b0;
      err_p      <= 1'b0;
      irq_p      <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      done_p  <= 1'b0;
      err_p   <= 1'b0;
      irq_p   <= 1'b0;
      if (mem_req)         pend <= 1'b1;
      else if (mem_rvalid) pend <= 1'b0;

      if (clear) begin
        state      <= W_IDLE;
        st_valid   <= 1'b0;
        bytes_done <= '0;
        word_k     <= 1'b0;
      end else begin
        case (state)
          W_IDLE: if (start) begin
            link_ptr   <= chain_base;
            link_cnt   <= '0;
            bytes_done <= '0;
            word_k     <= 1'b0;
            state      <= W_LREQ;
          end
          W_LREQ: if (!pause && !pend && !mem_req) begin
            mem_req  <= 1'b1;
            mem_addr <= link_ptr + (word_k ? ADDR_W'(4) : ADDR_W'(0));
            state    <= W_LWAIT;
          end
          W_LWAIT: if (mem_rvalid) begin
            if (!word_k) begin
              seg_len_q <= mem_rdata[SEG_LEN_W-1:0];
              lk_irq    <= mem_rdata[LK_IRQ];
              lk_eoc    <= mem_rdata[LK_EOC];
              if (mem_rdata[LK_BAD]) begin
                err_p <= 1'b1;
                state <= W_IDLE;
              end else begin
                word_k <= 1'b1;
                state  <= W_LREQ;
              end
            end else begin
              buf_addr <= mem_rdata[ADDR_W-1:0];
              seg_left <= seg_len_q;
              word_k   <= 1'b0;
              state    <= (seg_len_q == '0) ? W_SEGEND : W_DREQ;
            end
          end
          W_DREQ: if (!pause && !pend && !mem_req) begin
            mem_req  <= 1'b1;
            mem_addr <= {buf_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
            state    <= W_DWAIT;
          end
          W_DWAIT: if (mem_rvalid) begin
            data_word <= mem_rdata;
            state     <= W_SEND;
          end
          W_SEND: begin
            if (st_valid && st_ready) begin
              bytes_done <= bytes_done + LEN_W'(1);
              seg_left   <= seg_left - SEG_LEN_W'(1);
              buf_addr   <= buf_addr + ADDR_W'(1);
              if (seg_left == SEG_LEN_W'(1)) begin
                st_valid <= 1'b0;
                state    <= W_SEGEND;
              end else if (cur_lane == {LANE_W{1'b1}}) begin
                st_valid <= 1'b0;
                state    <= W_DREQ;
              end else if (pause) begin
                st_valid <= 1'b0;
              end else begin
                st_data <= nxt_byte;
              end
            end else if (!st_valid && !pause) begin
              st_valid <= 1'b1;
              st_data  <= cur_byte;
            end
          end
          W_SEGEND: begin
            irq_p <= lk_irq;
            if (lk_eoc) begin
              if (bytes_done == total_len) done_p <= 1'b1;
              else                         err_p  <= 1'b1;
              state <= W_IDLE;
            end else if (bytes_done >= total_len ||
                         link_cnt == LC_W'(MAX_LINKS - 1)) begin
              err_p <= 1'b1;
              state <= W_IDLE;
            end else begin
              link_ptr <= link_ptr + ADDR_W'(LINK_BYTES);
              link_cnt <= link_cnt + 1'b1;
              state    <= W_LREQ;
            end
          end
          default: state <= W_IDLE;
        endcase
      end
    end
  end

  // R4: a presented byte stays until taken
  a_r4_hold_stable: assert property (@(posedge clk) disable iff (rst)
    st_valid && !st_ready && !clear |=> st_valid && $stable(st_data));
  // R13: never a second request while one is pending
  a_r13_single_req: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !pend);
  // R10: the counter only steps by one or returns to zero
  a_r10_count_step: assert property (@(posedge clk) disable iff (rst)
    bytes_done != $past(bytes_done) |->
      (bytes_done == $past(bytes_done) + LEN_W'(1)) || (bytes_done == '0));
  // R11: a held pause issues no reads and raises no new byte
  a_r11_pause_no_req: assert property (@(posedge clk) disable iff (rst)
    pause && $past(pause) |-> !mem_req);
  a_r11_pause_no_byte: assert property (@(posedge clk) disable iff (rst)
    pause && !st_valid |=> !st_valid);
  // R5: done only with a matched length
  a_r5_done_len: assert property (@(posedge clk) disable iff (rst)
    done_p |-> bytes_done == total_len);
  // R6: done and error never together
  a_r6_excl: assert property (@(posedge clk) disable iff (rst)
    !(done_p && err_p));
  // R12: clear leaves the channel idle with a zero count
  a_r12_clear_idle: assert property (@(posedge clk) disable iff (rst)
    clear |=> !busy && bytes_done == '0 && !st_valid);
endmodule

// File: rtl/sg_chain_dma.sv
module sg_chain_dma #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 32,
  parameter int MAX_LINKS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              st_valid,
  output logic [7:0]        st_data,
  input  logic              st_ready,
  output logic              dma_done,
  output logic              dma_err,
  output logic              link_irq
);
  logic [ADDR_W-1:0] chain_base;
  logic [LEN_W-1:0]  total_len, bytes_done;
  logic              pause, start_p, clear_p, busy;

  sgdma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(busy), .done_p(dma_done), .count(bytes_done),
    .chain_base(chain_base), .total_len(total_len), .pause(pause),
    .start_p(start_p), .clear_p(clear_p)
  );

  sgdma_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_LINKS(MAX_LINKS)) u_walk (
    .clk(clk), .rst(rst), .start(start_p), .clear(clear_p), .pause(pause),
    .chain_base(chain_base), .total_len(total_len),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .st_valid(st_valid), .st_data(st_data),
    .st_ready(st_ready), .bytes_done(bytes_done), .busy(busy),
    .done_p(dma_done), .err_p(dma_err), .irq_p(link_irq)
  );
endmodule

// File: tb/tb_sg_chain_dma.sv
module tb_sg_chain_dma;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        st_valid;
  logic [7:0]  st_data;
  logic        st_ready = 1'b1;
  logic        dma_done, dma_err, link_irq;

  sg_chain_dma dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .st_valid(st_valid), .st_data(st_data), .st_ready(st_ready),
    .dma_done(dma_done), .dma_err(dma_err), .link_irq(link_irq)
  );

  logic [31:0] mem [0:255];
  int          lk_len [8];
  logic [31:0] lk_addr [8];
  logic [31:0] lk_fl [8];
  logic [7:0]  rx [0:255];
  logic [7:0]  exp_b [0:255];
  int n_chk = 0, n_fail = 0, n_mfail = 0;
  int n_done = 0, n_err = 0, n_irq = 0, n_req = 0, rx_n = 0, cyc = 0;
  int exp_n, exp_irq, sr, sd, se, si;
  bit exp_ok;
  bit rmode = 1'b0;
  logic [15:0] rl = 16'hACE1, ml = 16'h1234;
  logic [31:0] addr_q = '0;
  int  mcnt = 0;
  bit  mpend = 1'b0;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  // stream sink and pulse monitor
  always @(negedge clk) begin
    cyc++;
    rl = {rl[14:0], rl[15] ^ rl[13] ^ rl[12] ^ rl[10]};
    st_ready = rmode ? rl[0] : 1'b1;
    if (st_valid && st_ready) begin
      rx[rx_n % 256] = st_data;
      rx_n++;
    end
    if (dma_done) n_done++;
    if (dma_err)  n_err++;
    if (link_irq) n_irq++;
    if (cyc > 190000) begin
      $display("FAIL watchdog: run hung actual=%0d expected<=190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk + 1, n_fail + n_mfail + 1);
      $finish;
    end
  end

  // behavioural memory, variable latency
  always @(negedge clk) begin
    ml = {ml[14:0], ml[15] ^ ml[13] ^ ml[12] ^ ml[10]};
    if (mem_rvalid) mem_rvalid = 1'b0;
    if (mcnt > 0) begin
      mcnt--;
      if (mcnt == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem[addr_q[9:2]];
        mpend      = 1'b0;
      end
    end
    if (mem_req) begin
      n_req++;
      if (mpend) begin
        n_mfail++;
        $display("FAIL R13 overlapping request actual=1 expected=0");
      end
      addr_q = mem_addr;
      mpend  = 1'b1;
      mcnt   = 1 + int'(ml[1:0]);
    end
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic clear_links();
    for (int i = 0; i < 8; i++) begin
      lk_len[i] = 0; lk_addr[i] = 32'(256 + 32 * i); lk_fl[i] = '0;
    end
  endtask

  // writes the chain and derives the expected outcome from the requirements
  task automatic prep(input logic [31:0] total);
    exp_n = 0; exp_irq = 0; exp_ok = 1'b0;
    for (int i = 0; i < 8; i++) begin
      mem[4*i]   = lk_fl[i] | 32'(lk_len[i]);
      mem[4*i+1] = lk_addr[i];
      mem[4*i+2] = 32'hFFFF_FFFF;
      mem[4*i+3] = 32'hFFFF_FFFF;
    end
    for (int i = 0; i < 8; i++) begin
      if (lk_fl[i][30]) break;
      for (int b = 0; b < lk_len[i]; b++) begin
        exp_b[exp_n % 256] = pat(int'(lk_addr[i]) + b);
        exp_n++;
      end
      if (lk_fl[i][27]) exp_irq++;
      if (lk_fl[i][28]) begin exp_ok = (32'(exp_n) == total); break; end
      if (32'(exp_n) >= total) break;
    end
  endtask

  task automatic go(input logic [31:0] total);
    sr = rx_n; sd = n_done; se = n_err; si = n_irq;
    wr(2'd0, 32'h0);
    wr(2'd1, total);
    wr(2'd2, 32'h0);
  endtask

  task automatic fin(input string tag);
    int k = 0;
    int mism = 0;
    int bad_j = 0;
    logic [31:0] v;
    while (n_done + n_err == sd + se && k < 6000) begin
      @(negedge clk); k++;
    end
    repeat (4) @(negedge clk);
    chk(k < 6000, {tag, " R5 walk ends"}, k, 6000);
    chk(rx_n - sr == exp_n, {tag, " R4 byte count"}, rx_n - sr, exp_n);
    for (int j = 0; j < exp_n; j++)
      if (rx[(sr + j) % 256] !== exp_b[j % 256]) begin
        if (mism == 0) bad_j = j;
        mism++;
      end
    chk(mism == 0, {tag, " R4 stream bytes"}, rx[(sr + bad_j) % 256], exp_b[bad_j % 256]);
    chk(n_done - sd == int'(exp_ok), {tag, " R5 done pulses"}, n_done - sd, int'(exp_ok));
    chk(n_err - se == int'(!exp_ok), {tag, " R6 error pulses"}, n_err - se, int'(!exp_ok));
    chk(n_irq - si == exp_irq, {tag, " R9 irq pulses"}, n_irq - si, exp_irq);
    rd(2'd3, v);
    chk(v == 32'(exp_n), {tag, " R10 bytes done"}, v, exp_n);
    rd(2'd2, v);
    chk(v[28] == exp_ok && !v[27], {tag, " R5 done bit"}, v[28], int'(exp_ok));
  endtask

  task automatic run_chain(input logic [31:0] total, input string tag);
    prep(total); go(total); fin(tag);
  endtask

  initial begin
    logic [31:0] v;
    int tot, r0, q0;
    for (int w = 0; w < 256; w++)
      mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk(v == 0, "R1 register reset value", v, 0);
    end
    chk(!st_valid && n_req == 0, "R1 idle outputs", n_req, 0);

    // R2 R3 R4 sweep over lengths, alignments and chain depth
    for (int L = 0; L < 6; L++)
      for (int off = 0; off < 4; off++)
        for (int nl = 1; nl <= 3; nl++) begin
          clear_links();
          tot = 0;
          for (int i = 0; i < nl; i++) begin
            lk_len[i]  = ((L * 3 + i * 5) % 9) + 1;
            lk_addr[i] = 32'(256 + 32 * i + off);
            if (L % 2 == 1) lk_fl[i] = 32'hA000_0000; // R3 bits 29,31 ignored
            tot += lk_len[i];
          end
          lk_fl[nl-1][28] = 1'b1;
          rmode = ((L + off) % 2) == 1;
          run_chain(32'(tot), "R2 R3 sweep");
        end
    rmode = 1'b0;

    // eight links, end flag on the last one
    clear_links(); tot = 0;
    for (int i = 0; i < 8; i++) begin lk_len[i] = 3 + i; tot += lk_len[i]; end
    lk_fl[7][28] = 1'b1;
    run_chain(32'(tot), "R6 eight-link chain");

    // R6 no end flag within eight links
    lk_fl[7] = '0;
    run_chain(32'd1000, "R6 missing end flag");

    // R6 end flag reached short of the total
    clear_links(); lk_len[0] = 6; lk_len[1] = 7; lk_fl[1][28] = 1'b1;
    run_chain(32'd14, "R6 short chain");

    // R6 total reached before the end flag
    run_chain(32'd6, "R6 total reached early");

    // R9 interrupt requests on two of three links
    clear_links(); lk_len[0] = 4; lk_len[1] = 5; lk_len[2] = 6;
    lk_fl[0][27] = 1'b1; lk_fl[2][27] = 1'b1; lk_fl[2][28] = 1'b1;
    run_chain(32'd15, "R9 irq links");

    // R8 zero-length middle link
    clear_links(); lk_len[0] = 5; lk_len[1] = 0; lk_len[2] = 4; lk_fl[2][28] = 1'b1;
    run_chain(32'd9, "R8 zero-length link");

    // R7 bad link stops before its data
    clear_links(); lk_len[0] = 4; lk_len[1] = 8; lk_fl[1][30] = 1'b1; lk_fl[1][28] = 1'b1;
    q0 = n_req;
    run_chain(32'd12, "R7 bad link");
    chk(n_req - q0 == 4, "R7 memory reads", n_req - q0, 4);

    // R11 pause and exact resume
    clear_links(); lk_len[0] = 20; lk_len[1] = 19; lk_addr[1] = 32'd290; lk_fl[1][28] = 1'b1;
    prep(32'd39); go(32'd39);
    while (rx_n - sr < 5) @(negedge clk);
    wr(2'd2, 32'h0400_0000);
    repeat (12) @(negedge clk);
    r0 = rx_n; q0 = n_req;
    rd(2'd3, v);
    chk(v == 32'(r0 - sr), "R10 count while paused", v, r0 - sr);
    rd(2'd2, v);
    chk(v[26] && v[27], "R2 R11 busy and paused bits", v[27:26], 3);
    repeat (40) @(negedge clk);
    chk(rx_n == r0, "R11 no bytes while paused", rx_n, r0);
    chk(n_req == q0, "R11 no reads while paused", n_req, q0);
    wr(2'd2, 32'h0);
    fin("R11 resume");

    // R12 clear mid-transfer, then a fresh run
    clear_links(); lk_len[0] = 16; lk_len[1] = 16; lk_fl[1][28] = 1'b1;
    prep(32'd32); go(32'd32);
    while (rx_n - sr < 6) @(negedge clk);
    wr(2'd2, 32'h0200_0000);
    repeat (10) @(negedge clk);
    rd(2'd3, v);
    chk(v == 0, "R12 count after clear", v, 0);
    rd(2'd2, v);
    chk(v == 0, "R12 config after clear", v, 0);
    chk(n_done == sd && n_err == se, "R12 no pulse on clear", n_done + n_err, sd + se);
    run_chain(32'd32, "R12 restart after clear");

    chk(n_mfail == 0, "R13 single outstanding read", n_mfail, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail + n_mfail);
    $finish;
  end
endmodule